// File: doc/BRIEF.md
# Core Idle State Controller

This block sequences one processor core through its idle states. From the active state the core can drop into one of two light halts, an intermediate idle state that still answers coherence snoops, or a deep idle state in which every core clock is gated. Decoded idle requests arrive from the instruction path: a plain halt, a monitor-wait with a target depth, or a legacy level-2 or level-3 idle read. Wake sources come from the interrupt and system-management logic. The controller reports its state and drives the cache-flush handshake, the clock-gate enable and a snoop-service strobe.

The two light halts differ only in one respect. The halt entered through monitor-wait also wakes on a monitor event, provided the monitor is armed. Before the deep state gates clocks, the controller asks for a first-level cache flush and waits for it to complete. Any wake that arrives while it waits cancels the entry. In the deep state, snoops are absorbed and do not wake the core. The monitor-armed flag lives in this block and is kept across deep-idle entry and exit.

Top module: `core_idle_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the core goes to the active state. State codes on `state_o`: 0 active, 1 halt, 2 monitor-wait halt, 3 intermediate idle, 4 snoop service, 5 flush pending, 6 deep idle. After reset, every output is 0, including `mon_armed_o`.
- R2: In the active state, `req_halt` moves the core to state 1 on the next edge. State 1 returns to 0 on SMI, INIT, either local interrupt line, or a bus interrupt message, and ignores monitor events. Each return to state 0 from any idle state pulses `wake_o` high for exactly one cycle.
- R3: In the active state, a monitor-wait request with `mwait_depth` 0 enters state 2. State 2 leaves for state 0 on any state-1 wake source, and also on `mon_evt` while the monitor is armed. An unarmed monitor event leaves it in state 2.
- R4: In the active state, `req_lvl2`, or a monitor-wait with `mwait_depth` 1, enters state 3.
- R5: In state 3, `snoop_vld` without a wake moves the core to state 4 for one cycle with `snoop_svc_o` high, then back to state 3. A wake and a snoop in the same cycle go to state 0.
- R6: In the active state, `req_lvl3`, or a monitor-wait with `mwait_depth` 2 or more, enters state 5. `flush_req_o` stays high there, with clocks ungated, until `flush_done` arrives. The core then enters state 6.
- R7: In state 6, `clk_gate_o` is high, and `snoop_vld` causes neither an exit nor a snoop-service strobe.
- R8: State 6 exits to state 0 on SMI, INIT, either local interrupt line, a bus interrupt message, or an armed monitor event.
- R9: A wake source in state 5 aborts the entry: the next state is 0 and the clocks are never gated, even if `flush_done` arrives in the same cycle.
- R10: `mon_arm` sets `mon_armed_o`. A monitor event clears it. Without either, it holds its value, including across entry to and exit from state 6.
- R11: When several requests arrive in one active cycle, the deepest wins, in the order deep, intermediate, monitor-wait halt, halt.
- R12: Idle requests are ignored in every state other than active.
- R13: Reset takes effect from any state, including deep idle, and clears the gate enable on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_halt | input | 1 | Halt request |
| req_mwait | input | 1 | Monitor-wait request |
| mwait_depth | input | DEPTH_W | Target depth of the monitor-wait |
| req_lvl2 | input | 1 | Legacy level-2 idle read request |
| req_lvl3 | input | 1 | Legacy level-3 idle read request |
| mon_arm | input | 1 | Arms the address monitor |
| mon_evt | input | 1 | Monitor event (write to the watched line) |
| snoop_vld | input | 1 | Incoming bus snoop |
| wake_smi | input | 1 | System-management interrupt |
| wake_init | input | 1 | INIT request |
| wake_lint | input | N_LINT | Local interrupt lines |
| wake_busmsg | input | 1 | Interrupt message from the bus |
| flush_done | input | 1 | First-level flush completed |
| state_o | output | 3 | Current state code |
| flush_req_o | output | 1 | Flush request to the cache |
| clk_gate_o | output | 1 | Core clock-gate enable |
| snoop_svc_o | output | 1 | Snoop being serviced |
| wake_o | output | 1 | One-cycle wake strobe |
| mon_armed_o | output | 1 | Monitor armed flag |

## Verification
`state_o` mirrors the sequencer register, so a wrong next-state choice shows at the port on the edge after the stimulus that caused it. The bench samples one cycle after every stimulus. Two faults are less visible: a clock gate raised before the flush completes, and an armed flag lost across deep idle. Both can stay hidden until a later wake. The bench therefore holds `flush_done` low for several cycles and reads `mon_armed_o` after a non-monitor exit from deep idle.

// File: rtl/cis_pkg.sv
// Shared types for the core idle-state controller.
// Assumes: state codes are visible at the top port, so their values are fixed.
package cis_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_HALT   = 3'd1,
        ST_MHALT  = 3'd2,
        ST_IDLE2  = 3'd3,
        ST_SNOOP  = 3'd4,
        ST_FLUSH  = 3'd5,
        ST_DEEP   = 3'd6
    } cis_state_e;

    typedef enum logic [2:0] {
        RQ_NONE  = 3'd0,
        RQ_HALT  = 3'd1,
        RQ_MHALT = 3'd2,
        RQ_IDLE2 = 3'd3,
        RQ_DEEP  = 3'd4
    } cis_req_e;

endpackage

// File: rtl/cis_req_arb.sv
// Idle request arbiter: folds the decoded idle requests into one target.
// When several requests arrive together, the deepest one wins.
// Assumes: depth codes MID_CODE < DEEP_CODE; every code at or above DEEP_CODE means deep.
module cis_req_arb
    import cis_pkg::*;
#(
    parameter int DEPTH_W   = 2,
    parameter int MID_CODE  = 1,
    parameter int DEEP_CODE = 2
) (
    input  logic               req_halt,
    input  logic               req_mwait,
    input  logic [DEPTH_W-1:0] mwait_depth,
    input  logic               req_lvl2,
    input  logic               req_lvl3,
    output cis_req_e           pick
);
    localparam logic [DEPTH_W-1:0] MidC  = DEPTH_W'(MID_CODE);
    localparam logic [DEPTH_W-1:0] DeepC = DEPTH_W'(DEEP_CODE);

    logic want_deep, want_mid, want_mhalt;

    // Classify the monitor-wait depth and merge it with the legacy reads.
    always_comb begin
        want_deep  = req_lvl3 || (req_mwait && (mwait_depth >= DeepC));
        want_mid   = req_lvl2 || (req_mwait && (mwait_depth >= MidC) && (mwait_depth < DeepC));
        want_mhalt = req_mwait && (mwait_depth < MidC);
    end

    // Pick the deepest request present.
    always_comb begin
        if (want_deep)       pick = RQ_DEEP;
        else if (want_mid)   pick = RQ_IDLE2;
        else if (want_mhalt) pick = RQ_MHALT;
        else if (req_halt)   pick = RQ_HALT;
        else                 pick = RQ_NONE;
    end

endmodule

// File: rtl/cis_wake_merge.sv
// Wake source merge and monitor-armed flag.
// ext_wake covers every wake except the monitor. mon_wake is a monitor event
// seen while the monitor is armed.
// Assumes: all sources are already synchronous to clk.
module cis_wake_merge #(
    parameter int N_LINT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wake_smi,
    input  logic              wake_init,
    input  logic [N_LINT-1:0] wake_lint,
    input  logic              wake_busmsg,
    input  logic              mon_arm,
    input  logic              mon_evt,
    output logic              ext_wake,
    output logic              mon_wake,
    output logic              armed
);
    logic [N_LINT-1:0] lint_acc;

    // Chain OR across the local interrupt lines.
    genvar g;
    generate
        for (g = 0; g < N_LINT; g++) begin : g_lint
            if (g == 0) begin : g_first
                assign lint_acc[g] = wake_lint[g];
            end else begin : g_rest
                assign lint_acc[g] = lint_acc[g-1] | wake_lint[g];
            end
        end
    endgenerate

    // Combine the non-monitor wake causes and qualify the monitor event.
    always_comb begin
        ext_wake = wake_smi | wake_init | lint_acc[N_LINT-1] | wake_busmsg;
        mon_wake = mon_evt & armed;
    end

    // Armed flag: set by arm, cleared by event, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (mon_arm) armed <= 1'b1;
        else if (mon_evt) armed <= 1'b0;
    end

    assert_arm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_arm && !mon_evt) |=> (armed == $past(armed)));

    assert_arm_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mon_arm |=> armed);

endmodule

// File: rtl/core_idle_ctrl.sv
// Core idle-state controller: sequences one core through its idle states.
// The states are active, halt, monitor-wait halt, intermediate idle with a
// snoop-service sub-state, flush pending, and deep idle with clocks gated.
// Assumes: synchronous inputs and synchronous active-low reset. A flush
// request, once raised, is held until flush_done or until a wake cancels it.
module core_idle_ctrl
    import cis_pkg::*;
#(
    parameter int DEPTH_W   = 2,
    parameter int MID_CODE  = 1,
    parameter int DEEP_CODE = 2,
    parameter int N_LINT    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_halt,
    input  logic               req_mwait,
    input  logic [DEPTH_W-1:0] mwait_depth,
    input  logic               req_lvl2,
    input  logic               req_lvl3,
    input  logic               mon_arm,
    input  logic               mon_evt,
    input  logic               snoop_vld,
    input  logic               wake_smi,
    input  logic               wake_init,
    input  logic [N_LINT-1:0]  wake_lint,
    input  logic               wake_busmsg,
    input  logic               flush_done,
    output logic [2:0]         state_o,
    output logic               flush_req_o,
    output logic               clk_gate_o,
    output logic               snoop_svc_o,
    output logic               wake_o,
    output logic               mon_armed_o
);
    cis_state_e st, st_nxt;
    cis_req_e   pick;
    logic       ext_wake, mon_wake, any_wake, armed;

    cis_req_arb #(
        .DEPTH_W  (DEPTH_W),
        .MID_CODE (MID_CODE),
        .DEEP_CODE(DEEP_CODE)
    ) u_arb (
        .req_halt   (req_halt),
        .req_mwait  (req_mwait),
        .mwait_depth(mwait_depth),
        .req_lvl2   (req_lvl2),
        .req_lvl3   (req_lvl3),
        .pick       (pick)
    );

    cis_wake_merge #(
        .N_LINT(N_LINT)
    ) u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_smi   (wake_smi),
        .wake_init  (wake_init),
        .wake_lint  (wake_lint),
        .wake_busmsg(wake_busmsg),
        .mon_arm    (mon_arm),
        .mon_evt    (mon_evt),
        .ext_wake   (ext_wake),
        .mon_wake   (mon_wake),
        .armed      (armed)
    );

    // Wake set for every idle state except the plain halt.
    assign any_wake = ext_wake | mon_wake;

    // Next-state selection for the idle sequencer.
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_ACTIVE: begin
                unique case (pick)
                    RQ_DEEP:  st_nxt = ST_FLUSH;
                    RQ_IDLE2: st_nxt = ST_IDLE2;
                    RQ_MHALT: st_nxt = ST_MHALT;
                    RQ_HALT:  st_nxt = ST_HALT;
                    default:  st_nxt = ST_ACTIVE;
                endcase
            end
            ST_HALT:  if (ext_wake) st_nxt = ST_ACTIVE;
            ST_MHALT: if (any_wake) st_nxt = ST_ACTIVE;
            ST_IDLE2: begin
                if (any_wake)       st_nxt = ST_ACTIVE;
                else if (snoop_vld) st_nxt = ST_SNOOP;
            end
            ST_SNOOP: st_nxt = ST_IDLE2;
            ST_FLUSH: begin
                if (any_wake)        st_nxt = ST_ACTIVE;
                else if (flush_done) st_nxt = ST_DEEP;
            end
            ST_DEEP:  if (any_wake) st_nxt = ST_ACTIVE;
            default:  st_nxt = ST_ACTIVE;
        endcase
    end

    // State register and one-cycle wake strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_ACTIVE;
            wake_o <= 1'b0;
        end else begin
            st     <= st_nxt;
            wake_o <= (st != ST_ACTIVE) && (st_nxt == ST_ACTIVE);
        end
    end

    // Decode the port-level outputs from the state.
    always_comb begin
        state_o     = st;
        flush_req_o = (st == ST_FLUSH);
        clk_gate_o  = (st == ST_DEEP);
        snoop_svc_o = (st == ST_SNOOP);
        mon_armed_o = armed;
    end

    assert_gate_after_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_gate_o) |-> $past(flush_req_o && flush_done));

    assert_snoop_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_svc_o |=> (state_o == 3'd3) && !snoop_svc_o);

    assert_deep_absorbs_snoop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_gate_o && snoop_vld && !any_wake) |=> clk_gate_o);

    assert_flush_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req_o && any_wake) |=> (state_o == 3'd0) && !clk_gate_o);

    assert_wake_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    assert_wake_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (state_o == 3'd0));

    assert_halt_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && !ext_wake) |=> (state_o == 3'd1));

    assert_outputs_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_req_o, clk_gate_o, snoop_svc_o}));

endmodule

// File: tb/tb_core_idle_ctrl.sv
`timescale 1ns/1ps
module tb_core_idle_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_halt, req_mwait, req_lvl2, req_lvl3;
    logic [1:0] mwait_depth;
    logic       mon_arm, mon_evt, snoop_vld;
    logic       wake_smi, wake_init, wake_busmsg, flush_done;
    logic [1:0] wake_lint;
    logic [2:0] state_o;
    logic       flush_req_o, clk_gate_o, snoop_svc_o, wake_o, mon_armed_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    core_idle_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_halt(req_halt), .req_mwait(req_mwait), .mwait_depth(mwait_depth),
        .req_lvl2(req_lvl2), .req_lvl3(req_lvl3),
        .mon_arm(mon_arm), .mon_evt(mon_evt), .snoop_vld(snoop_vld),
        .wake_smi(wake_smi), .wake_init(wake_init), .wake_lint(wake_lint),
        .wake_busmsg(wake_busmsg), .flush_done(flush_done),
        .state_o(state_o), .flush_req_o(flush_req_o), .clk_gate_o(clk_gate_o),
        .snoop_svc_o(snoop_svc_o), .wake_o(wake_o), .mon_armed_o(mon_armed_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        req_halt = 0; req_mwait = 0; mwait_depth = 0; req_lvl2 = 0; req_lvl3 = 0;
        mon_arm = 0; mon_evt = 0; snoop_vld = 0;
        wake_smi = 0; wake_init = 0; wake_lint = 0; wake_busmsg = 0; flush_done = 0;
    endtask

    // Advance one edge and sample 1 ns later; inputs are cleared after sampling.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic step();
        tick();
        quiet();
    endtask

    task automatic t_reset();
        quiet();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        chk("R1 state", state_o, 0);
        chk("R1 outputs", {flush_req_o, clk_gate_o, snoop_svc_o, wake_o}, 0);
        chk("R1 armed", mon_armed_o, 0);
    endtask

    task automatic t_halt();
        mon_arm = 1; step();
        chk("R10 arm set", mon_armed_o, 1);
        req_halt = 1; step();
        chk("R2 enter halt", state_o, 1);
        req_lvl3 = 1; step();
        chk("R12 request ignored in halt", state_o, 1);
        mon_evt = 1; step();
        chk("R2 monitor ignored in halt", state_o, 1);
        chk("R10 event clears armed", mon_armed_o, 0);
        wake_lint = 2'b10; step();
        chk("R2 lint wakes halt", state_o, 0);
        chk("R2 wake pulse", wake_o, 1);
        step();
        chk("R2 wake one cycle", wake_o, 0);
    endtask

    task automatic t_mhalt();
        req_mwait = 1; mwait_depth = 0; step();
        chk("R3 enter mwait halt", state_o, 2);
        mon_evt = 1; step();
        chk("R3 unarmed event stays", state_o, 2);
        mon_arm = 1; step();
        mon_evt = 1; step();
        chk("R3 armed event wakes", state_o, 0);
        chk("R3 wake pulse", wake_o, 1);
        req_mwait = 1; mwait_depth = 0; step();
        wake_smi = 1; step();
        chk("R3 smi wakes mwait halt", state_o, 0);
    endtask

    task automatic t_idle2();
        req_lvl2 = 1; step();
        chk("R4 lvl2 enters idle2", state_o, 3);
        snoop_vld = 1; step();
        chk("R5 snoop sub-state", state_o, 4);
        chk("R5 snoop strobe", snoop_svc_o, 1);
        step();
        chk("R5 back to idle2", state_o, 3);
        chk("R5 strobe ends", snoop_svc_o, 0);
        snoop_vld = 1; wake_init = 1; step();
        chk("R5 wake beats snoop", state_o, 0);
        req_mwait = 1; mwait_depth = 1; step();
        chk("R4 mwait depth1 enters idle2", state_o, 3);
        wake_busmsg = 1; step();
        chk("R4 exit idle2", state_o, 0);
    endtask

    task automatic t_deep();
        mon_arm = 1; step();
        req_lvl3 = 1; step();
        chk("R6 flush pending", state_o, 5);
        chk("R6 flush request", flush_req_o, 1);
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R6 hold until done", {state_o, flush_req_o, clk_gate_o}, {3'd5, 1'b1, 1'b0});
        end
        flush_done = 1; step();
        chk("R6 deep reached", state_o, 6);
        chk("R7 clocks gated", clk_gate_o, 1);
        chk("R6 flush request drops", flush_req_o, 0);
        snoop_vld = 1; tick();
        chk("R7 snoop absorbed", state_o, 6);
        chk("R7 no snoop strobe", snoop_svc_o, 0);
        step();
        chk("R7 still deep", state_o, 6);
        wake_busmsg = 1; step();
        chk("R8 bus message wakes deep", state_o, 0);
        chk("R8 wake pulse", wake_o, 1);
        chk("R10 armed kept across deep", mon_armed_o, 1);
        req_mwait = 1; mwait_depth = 3; step();
        chk("R6 mwait depth3 flush", state_o, 5);
        flush_done = 1; step();
        chk("R6 deep via mwait", state_o, 6);
        mon_evt = 1; step();
        chk("R8 monitor wakes deep", state_o, 0);
        chk("R10 armed cleared", mon_armed_o, 0);
    endtask

    task automatic t_abort();
        req_mwait = 1; mwait_depth = 2; step();
        chk("R6 mwait depth2 flush", state_o, 5);
        wake_lint = 2'b01; flush_done = 1; step();
        chk("R9 abort to active", state_o, 0);
        chk("R9 no gate", clk_gate_o, 0);
        step();
        chk("R9 stays ungated", clk_gate_o, 0);
    endtask

    task automatic t_prio();
        req_halt = 1; req_lvl2 = 1; req_mwait = 1; mwait_depth = 0; step();
        chk("R11 idle2 wins", state_o, 3);
        wake_smi = 1; step();
        req_halt = 1; req_lvl3 = 1; step();
        chk("R11 deep wins", state_o, 5);
        wake_init = 1; step();
        req_halt = 1; req_mwait = 1; mwait_depth = 0; step();
        chk("R11 mwait halt over halt", state_o, 2);
        req_lvl2 = 1; step();
        chk("R12 request ignored in mwait halt", state_o, 2);
        wake_smi = 1; step();
    endtask

    task automatic t_reset_any();
        mon_arm = 1; step();
        req_lvl3 = 1; step();
        flush_done = 1; step();
        chk("R13 setup deep", state_o, 6);
        rst_n = 0; tick();
        rst_n = 1;
        chk("R13 reset from deep", state_o, 0);
        chk("R13 gate cleared", clk_gate_o, 0);
        chk("R1 armed cleared by reset", mon_armed_o, 0);
    endtask

    initial begin
        quiet();
        rst_n = 0;
        t_reset();
        t_halt();
        t_mhalt();
        t_idle2();
        t_deep();
        t_abort();
        t_prio();
        t_reset_any();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule